// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block decides whether a twisted-pair receive channel has a working link partner. It watches a strobe that marks each detected link test pulse and a signal that shows ordinary receive traffic, and from them it keeps one of two states: link up or link down. All timing is counted in ticks of a one-microsecond strobe from elsewhere in the chip, so the block runs on any system clock.

While the link is down, each pulse is judged by its distance from the previous pulse. Pulses that come too soon or too late are rejected and restart the qualification. A set number of well-spaced pulses in a row brings the link up. As an option, the start of a receive burst can also count toward that number. While the link is up, a watchdog timer runs. Receive traffic or a well-spaced pulse restarts it. If it runs out, the link drops. The state drives a status bit and an LED output. All thresholds are parameters, so a bench can shrink them.

Top module: `link_integrity_mon`

## Requirements
- R1: After reset `link_ok_o` is 0, `link_fail_led_o` is 1, and all counters are clear.
- R2: `link_fail_led_o` is always the inverse of `link_ok_o`.
- R3: A pulse on `lp_det_i` is valid only if an earlier reference event exists and the number of `tick_us_i` cycles since that reference lies in [MIN_GAP_US, MAX_GAP_US], bounds included. The first pulse after reset or after a link drop only sets the reference.
- R4: While the link is down, PASS_CNT valid events in a row bring the link up. `link_ok_o` rises on the clock edge that registers the last of them.
- R5: While the link is down, a pulse with an out-of-range interval clears the valid count to zero and becomes the new reference.
- R6: While the link is up, LOSS_US ticks with no restart take the link down. The drop happens on the edge of the last such tick.
- R7: While the link is up, `rx_act_i` high or a valid pulse restarts the loss timer.
- R8: While the link is up, a pulse that came too soon does not restart the loss timer.
- R9: With RX_COUNTS=1, a rising edge of `rx_act_i` while the link is down counts as one valid event and sets the reference. With RX_COUNTS=0 it has no effect while the link is down.
- R10: `link_ok_o` changes only on a cycle in which `tick_us_i`, `lp_det_i` or `rx_act_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle strobe once per microsecond |
| lp_det_i | input | 1 | One-cycle strobe per detected link test pulse |
| rx_act_i | input | 1 | High while a packet is being received |
| link_ok_o | output | 1 | Link state for the status register, 1 = up |
| link_fail_led_o | output | 1 | LED drive, high while the link is down |

## Verification
The bench builds the monitor with LOSS_US=40, MIN_GAP_US=4, MAX_GAP_US=30 and PASS_CNT=2. Every pulse spacing from 0 to 33 ticks can then be swept, which covers both edges of the valid window and the saturated interval counter. Loss expiry, restarts and rejected short pulses also fit within a few dozen cycles each. A second copy built with RX_COUNTS=0 receives the same stimulus, so the receive-traffic option is checked in both settings.

// File: rtl/lim_pkg.sv
package lim_pkg;
  typedef enum logic {
    LINK_DOWN = 1'b0,
    LINK_UP   = 1'b1
  } link_state_e;
endpackage

// File: rtl/lim_gap_timer.sv
// Ticks since last reference event, saturating one above the valid window.
module lim_gap_timer #(
  parameter int MAX_GAP_US = 64000,
  localparam int SatVal = MAX_GAP_US + 1,
  localparam int W = $clog2(SatVal + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clear_i,
  output logic [W-1:0] gap_o
);
  localparam logic [W-1:0] SatV = W'(SatVal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    gap_o <= '0;
    else if (clear_i)               gap_o <= '0;
    else if (tick_i && gap_o != SatV) gap_o <= gap_o + 1'b1;
  end
endmodule

// File: rtl/lim_loss_timer.sv
module lim_loss_timer #(
  parameter int LOSS_US = 64000,
  localparam int W = $clog2(LOSS_US + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         restart_i,
  output logic         expire_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LastV = W'(LOSS_US - 1);

  assign expire_o = run_i && tick_i && !restart_i && (cnt_o == LastV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (!run_i || restart_i)     cnt_o <= '0;
    else if (expire_o)                cnt_o <= '0;
    else if (tick_i)                  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lim_link_fsm.sv
module lim_link_fsm
  import lim_pkg::*;
#(
  parameter int MIN_GAP_US = 4000,
  parameter int MAX_GAP_US = 64000,
  parameter int PASS_CNT   = 2,
  localparam int GW = $clog2(MAX_GAP_US + 2),
  localparam int CW = $clog2(PASS_CNT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lp_i,
  input  logic          rx_lvl_i,
  input  logic          rx_evt_i,
  input  logic [GW-1:0] gap_i,
  input  logic          loss_exp_i,
  output logic          gap_clr_o,
  output logic          loss_rst_o,
  output link_state_e   state_o
);
  localparam logic [GW-1:0] MinV  = GW'(MIN_GAP_US);
  localparam logic [GW-1:0] MaxV  = GW'(MAX_GAP_US);
  localparam logic [CW-1:0] PassV = CW'(PASS_CNT);

  link_state_e state_n;
  logic [CW-1:0] vcnt_q, vcnt_n;
  logic has_ref_q, has_ref_n;
  logic gap_ok;

  assign gap_ok = has_ref_q && (gap_i >= MinV) && (gap_i <= MaxV);

  always_comb begin
    state_n    = state_o;
    vcnt_n     = vcnt_q;
    has_ref_n  = has_ref_q;
    gap_clr_o  = 1'b0;
    loss_rst_o = 1'b0;
    unique case (state_o)
      LINK_DOWN: begin
        if (lp_i) begin
          gap_clr_o = 1'b1;
          has_ref_n = 1'b1;
          if (gap_ok) begin
            if (vcnt_q + 1'b1 >= PassV) begin
              state_n = LINK_UP;
              vcnt_n  = '0;
            end else begin
              vcnt_n = vcnt_q + 1'b1;
            end
          end else begin
            vcnt_n = '0;
          end
        end else if (rx_evt_i) begin
          gap_clr_o = 1'b1;
          has_ref_n = 1'b1;
          if (vcnt_q + 1'b1 >= PassV) begin
            state_n = LINK_UP;
            vcnt_n  = '0;
          end else begin
            vcnt_n = vcnt_q + 1'b1;
          end
        end
      end
      LINK_UP: begin
        if (lp_i) begin
          gap_clr_o = 1'b1;
          has_ref_n = 1'b1;
          if (gap_ok) loss_rst_o = 1'b1;
        end
        if (rx_lvl_i) loss_rst_o = 1'b1;
        if (loss_exp_i) begin
          state_n   = LINK_DOWN;
          vcnt_n    = '0;
          has_ref_n = 1'b0;
          gap_clr_o = 1'b1;
        end
      end
      default: state_n = LINK_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o   <= LINK_DOWN;
      vcnt_q    <= '0;
      has_ref_q <= 1'b0;
    end else begin
      state_o   <= state_n;
      vcnt_q    <= vcnt_n;
      has_ref_q <= has_ref_n;
    end
  end
endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon
  import lim_pkg::*;
#(
  parameter int LOSS_US    = 64000,
  parameter int MIN_GAP_US = 4000,
  parameter int MAX_GAP_US = 64000,
  parameter int PASS_CNT   = 2,
  parameter bit RX_COUNTS  = 1'b1,
  localparam int GW = $clog2(MAX_GAP_US + 2),
  localparam int LW = $clog2(LOSS_US + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_us_i,
  input  logic lp_det_i,
  input  logic rx_act_i,
  output logic link_ok_o,
  output logic link_fail_led_o
);
  link_state_e   state;
  logic [GW-1:0] gap;
  logic [LW-1:0] loss_cnt;
  logic gap_clr, loss_rst, loss_exp, rx_evt;

  generate
    if (RX_COUNTS) begin : g_rx_edge
      logic rx_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rx_q <= 1'b0;
        else         rx_q <= rx_act_i;
      end
      assign rx_evt = rx_act_i && !rx_q;
    end else begin : g_rx_off
      assign rx_evt = 1'b0;
    end
  endgenerate

  lim_gap_timer #(.MAX_GAP_US(MAX_GAP_US)) u_gap (
    .clk_i, .rst_ni, .tick_i(tick_us_i), .clear_i(gap_clr), .gap_o(gap)
  );

  lim_loss_timer #(.LOSS_US(LOSS_US)) u_loss (
    .clk_i, .rst_ni, .run_i(state == LINK_UP), .tick_i(tick_us_i),
    .restart_i(loss_rst), .expire_o(loss_exp), .cnt_o(loss_cnt)
  );

  lim_link_fsm #(
    .MIN_GAP_US(MIN_GAP_US), .MAX_GAP_US(MAX_GAP_US), .PASS_CNT(PASS_CNT)
  ) u_fsm (
    .clk_i, .rst_ni, .lp_i(lp_det_i), .rx_lvl_i(rx_act_i), .rx_evt_i(rx_evt),
    .gap_i(gap), .loss_exp_i(loss_exp), .gap_clr_o(gap_clr),
    .loss_rst_o(loss_rst), .state_o(state)
  );

  assign link_ok_o       = (state == LINK_UP);
  assign link_fail_led_o = (state != LINK_UP);
endmodule

// File: rtl/link_integrity_mon_chk.sv
module link_integrity_mon_chk #(
  parameter int LOSS_US    = 64000,
  parameter int MAX_GAP_US = 64000,
  parameter int GW = 17,
  parameter int LW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_us_i,
  input logic          lp_det_i,
  input logic          rx_act_i,
  input logic          link_ok_o,
  input logic          link_fail_led_o,
  input logic [GW-1:0] gap,
  input logic [LW-1:0] loss_cnt
);
  assert_led_inverse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_fail_led_o == !link_ok_o);

  assert_quiet_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_us_i && !lp_det_i && !rx_act_i) |=> $stable(link_ok_o));

  assert_rise_on_event_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ok_o) |-> $past(lp_det_i || rx_act_i));

  assert_drop_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_ok_o) |-> $past(tick_us_i));

  assert_loss_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_cnt < LW'(LOSS_US));

  assert_loss_idle_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_ok_o |-> loss_cnt == '0);

  assert_gap_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap <= GW'(MAX_GAP_US + 1));
endmodule

bind link_integrity_mon link_integrity_mon_chk #(
  .LOSS_US(LOSS_US), .MAX_GAP_US(MAX_GAP_US), .GW(GW), .LW(LW)
) u_chk (.*);

// File: tb/link_integrity_mon_test.sv
`timescale 1ns/1ps
module link_integrity_mon_test;
  localparam int LOSS = 40;
  localparam int MING = 4;
  localparam int MAXG = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, lp = 1'b0, rx = 1'b0;
  logic ok, led, ok_nr, led_nr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  link_integrity_mon #(.LOSS_US(LOSS), .MIN_GAP_US(MING), .MAX_GAP_US(MAXG),
    .PASS_CNT(2), .RX_COUNTS(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .lp_det_i(lp),
    .rx_act_i(rx), .link_ok_o(ok), .link_fail_led_o(led));

  link_integrity_mon #(.LOSS_US(LOSS), .MIN_GAP_US(MING), .MAX_GAP_US(MAXG),
    .PASS_CNT(2), .RX_COUNTS(1'b0)) uut_norx (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .lp_det_i(lp),
    .rx_act_i(rx), .link_ok_o(ok_nr), .link_fail_led_o(led_nr));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 0; lp = 0; rx = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic pulse();
    lp = 1'b1; @(posedge clk); #1 lp = 1'b0;
  endtask

  task automatic adv(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick = 1'b0;
    end
  endtask

  task automatic rx_burst(input int n);
    rx = 1'b1; repeat (n) @(posedge clk); #1 rx = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic bring_up();
    do_reset(); pulse(); adv(10); pulse(); adv(10); pulse();
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 link_ok", ok, 1'b0);
    chk("R1 led", led, 1'b1);

    // R3/R4 interval sweep: three pulses at spacing g
    for (int g = 0; g <= MAXG + 3; g++) begin
      do_reset();
      pulse(); adv(g); pulse();
      chk("R3 one valid not enough", ok, 1'b0);
      adv(g); pulse();
      chk("R3 window sweep", ok, (g >= MING && g <= MAXG));
      chk("R2 led inverse", led, !(g >= MING && g <= MAXG));
    end

    // R3 first pulse only a reference; R4 edge timing
    do_reset(); pulse(); adv(10); pulse();
    chk("R3 first pulse reference", ok, 1'b0);
    adv(10); lp = 1'b1; @(posedge clk); #1;
    chk("R4 up on completing edge", ok, 1'b1);
    lp = 1'b0;

    // R5 invalid interval clears count
    do_reset(); pulse(); adv(10); pulse(); adv(2); pulse(); adv(10); pulse();
    chk("R5 count cleared", ok, 1'b0);
    adv(10); pulse();
    chk("R5 recount reaches pass", ok, 1'b1);

    // R5 too-late interval clears count
    do_reset(); pulse(); adv(10); pulse(); adv(MAXG + 1); pulse(); adv(10); pulse();
    chk("R5 late interval cleared", ok, 1'b0);

    // R6 loss expiry at exactly LOSS ticks
    bring_up();
    adv(LOSS - 1);
    chk("R6 up before expiry", ok, 1'b1);
    adv(1);
    chk("R6 down at expiry", ok, 1'b0);
    chk("R2 led on at drop", led, 1'b1);

    // R6 after drop, first pulse is only a reference again
    pulse(); adv(10); pulse();
    chk("R3 after drop reference", ok, 1'b0);

    // R7 rx activity restarts loss timer
    bring_up();
    adv(LOSS - 1); rx = 1'b1; @(posedge clk); #1 rx = 1'b0;
    adv(LOSS - 1);
    chk("R7 rx restart", ok, 1'b1);
    adv(1);
    chk("R7 expiry after rx restart", ok, 1'b0);

    // R7 valid pulse restarts loss timer
    bring_up();
    adv(10); pulse(); adv(LOSS - 1);
    chk("R7 pulse restart", ok, 1'b1);
    adv(1);
    chk("R7 expiry after pulse restart", ok, 1'b0);

    // R8 short pulse does not restart
    bring_up();
    adv(2); pulse(); adv(LOSS - 3);
    chk("R8 still up", ok, 1'b1);
    adv(1);
    chk("R8 short pulse ignored", ok, 1'b0);

    // R9 rx bursts while down
    do_reset();
    rx_burst(3);
    chk("R9 one burst not enough", ok, 1'b0);
    rx_burst(3);
    chk("R9 two bursts pass", ok, 1'b1);
    chk("R9 option off stays down", ok_nr, 1'b0);
    chk("R9 option off led", led_nr, 1'b1);

    // R9 burst sets reference for a following pulse
    do_reset();
    rx_burst(1); adv(10); pulse();
    chk("R9 burst plus pulse", ok, 1'b1);
    chk("R9 option off no count", ok_nr, 1'b0);

    // R10 hold with no activity
    bring_up();
    repeat (20) @(posedge clk); #1;
    chk("R10 stable when idle", ok, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule